// File: doc/BRIEF.md
# Graphics DRAM Configuration Command Decoder

This block sits on the device side of a synchronous graphics DRAM command port. On every rising clock edge it samples the chip select, the row, column and write-enable strobes, the special-function strobe, the bank-select bit, ten address bits and the 32-bit data bus. From these it picks out the commands that change the device's configuration and applies them.

The plain mode-programming command sets the read latency and the write mode. The mode-programming command with the special-function strobe high loads a colour word or a mask word from the data bus. Activate and precharge are decoded only to track whether a row is open. No-operation and deselect cycles leave every register as it was.

Bad encodings are rejected. A reserved latency code, a vendor test setting, or a request to load colour and mask together changes nothing. Each of these raises the error output for exactly one cycle. Every output is registered and shows the effect of a command in the cycle after the edge that captured it.

Top module: `sgcfg_decoder`

## Requirements
- R1: While rst is high and after it falls, cas_lat is 2, write_single is 0, row_active is 0, cmd_err is 0, and color_q and mask_q are zero.
- R2: A mode-programming command in the idle state (cs_n, ras_n, cas_n, we_n and dsf all low) with a legal encoding sets cas_lat to the latency in clocks given by addr[6:4] (001 = 1, 010 = 2, 011 = 3). It also sets write_single to bank_sel (1 = single-location writes, 0 = burst writes). Both outputs show the new values one cycle after the capturing edge, and addr[9] has no effect.
- R3: A mode-programming command in the idle state is rejected when addr[6:4] is 000, when addr[6] is 1, or when addr[8:7] is nonzero. A rejected command leaves cas_lat and write_single unchanged and raises cmd_err in the following cycle.
- R4: Activate (cs_n and ras_n low, cas_n and we_n high) sets row_active, and precharge (cs_n, ras_n and we_n low, cas_n high) clears it. While row_active is 1, a mode-programming command is ignored and raises no error.
- R5: A special-load command (cs_n, ras_n, cas_n and we_n low, dsf high) is accepted whether or not a row is open, and it completes in one clock. With addr[6]=1 and addr[5]=0, color_q takes the data bus word. With addr[5]=1 and addr[6]=0, mask_q takes the data bus word. With both bits low, neither register changes.
- R6: A special-load command with addr[6] and addr[5] both high loads neither register and raises cmd_err in the following cycle.
- R7: A no-operation command (cs_n low, ras_n, cas_n and we_n high) and any cycle with cs_n high change no register and raise no error, whatever the address and data buses carry.
- R8: cmd_err is high only in the cycle right after a command rejected under R3 or R6, so it drops back after one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| dsf | input | 1 | Special-function strobe, high selects the special load |
| bank_sel | input | 1 | Bank-select bit, used as the write-mode select when programming |
| addr | input | 10 | Address bus carrying the programming fields |
| dq | input | 32 | Data bus word for the colour and mask loads |
| cas_lat | output | 2 | Programmed read latency in clocks (1 to 3) |
| write_single | output | 1 | 1 = single-location writes, 0 = burst writes |
| row_active | output | 1 | A row is open (activate seen, no precharge since) |
| color_q | output | 32 | Colour register |
| mask_q | output | 32 | Mask register |
| cmd_err | output | 1 | One-cycle pulse after a rejected command |

## Verification
On every cycle the assertions check several rules. A no-operation or deselect cycle leaves all state stable. A special load takes the data word into exactly the selected register. Both rejection cases leave the registers untouched and pulse the error. The latency output never holds the unused code 0. An error pulse always has a rejected command in the cycle before it. Only the bench scenarios can show the full decode table of the mode-programming command: every latency and test code with both bank-select values and addr[9] both ways, checked against values the bench works out itself. The bench also covers the interaction with the open-row state, where programming must be ignored while a row is open while special loads still go through.

// File: rtl/sgcfg_pkg.sv
package sgcfg_pkg;

  typedef enum logic [2:0] {
    CMD_QUIET,
    CMD_ACT,
    CMD_PRE,
    CMD_PROG,
    CMD_SLOAD,
    CMD_OTHER
  } cmd_t;

  // Strobe decode: a high chip select deselects the device.
  function automatic cmd_t decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n,
                                      input logic dsf);
    cmd_t c;
    if (cs_n) begin
      c = CMD_QUIET;
    end else begin
      unique case ({ras_n, cas_n, we_n})
        3'b111:  c = CMD_QUIET;
        3'b011:  c = CMD_ACT;
        3'b010:  c = CMD_PRE;
        3'b000:  c = dsf ? CMD_SLOAD : CMD_PROG;
        default: c = CMD_OTHER;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/sgcfg_cmd_decode.sv
module sgcfg_cmd_decode
  import sgcfg_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  input  logic dsf,
  output logic is_act,
  output logic is_pre,
  output logic is_prog,
  output logic is_sload
);
  cmd_t cmd;

  always_comb begin
    cmd      = decode_cmd(cs_n, ras_n, cas_n, we_n, dsf);
    is_act   = (cmd == CMD_ACT);
    is_pre   = (cmd == CMD_PRE);
    is_prog  = (cmd == CMD_PROG);
    is_sload = (cmd == CMD_SLOAD);
  end
endmodule

// File: rtl/sgcfg_mode_reg.sv
module sgcfg_mode_reg #(
  parameter int LAT_W   = 3,
  parameter int TEST_W  = 2,
  parameter int OUT_W   = 2,
  parameter int LAT_MAX = 3,
  parameter int LAT_RST = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              prog_go,
  input  logic [LAT_W-1:0]  lat_code,
  input  logic [TEST_W-1:0] test_code,
  input  logic              mode_bit,
  output logic              reject,
  output logic [OUT_W-1:0]  cas_lat,
  output logic              write_single
);
  localparam logic [LAT_W-1:0] LAT_HI  = LAT_W'(LAT_MAX);
  localparam logic [OUT_W-1:0] RST_VAL = OUT_W'(LAT_RST);

  logic lat_ok;
  logic test_ok;

  always_comb begin
    lat_ok  = (lat_code != '0) && (lat_code <= LAT_HI);
    test_ok = (test_code == '0);
    reject  = !(lat_ok && test_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cas_lat      <= RST_VAL;
      write_single <= 1'b0;
    end else if (prog_go && !reject) begin
      cas_lat      <= OUT_W'(lat_code);
      write_single <= mode_bit;
    end
  end
endmodule

// File: rtl/sgcfg_word_reg.sv
module sgcfg_word_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= din;
  end
endmodule

// File: rtl/sgcfg_decoder.sv
module sgcfg_decoder #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              ras_n,
  input  logic              cas_n,
  input  logic              we_n,
  input  logic              dsf,
  input  logic              bank_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq,
  output logic [1:0]        cas_lat,
  output logic              write_single,
  output logic              row_active,
  output logic [DATA_W-1:0] color_q,
  output logic [DATA_W-1:0] mask_q,
  output logic              cmd_err
);
  // Field positions that the command format fixes.
  localparam int LAT_LSB  = 4;
  localparam int LAT_W    = 3;
  localparam int TEST_LSB = 7;
  localparam int TEST_W   = 2;
  localparam int COLOR_B  = 6;
  localparam int MASK_B   = 5;
  localparam int N_WORDS  = 2;

  logic is_act, is_pre, is_prog, is_sload;
  logic prog_go, prog_reject;
  logic sel_both;
  logic [N_WORDS-1:0] sel_bits;
  logic [N_WORDS-1:0] word_load;
  logic [DATA_W-1:0]  word_q [N_WORDS];
  logic unused_addr;

  assign unused_addr = ^{addr[ADDR_W-1:TEST_LSB+TEST_W], addr[LAT_LSB-1:0]};

  sgcfg_cmd_decode u_dec (
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .dsf      (dsf),
    .is_act   (is_act),
    .is_pre   (is_pre),
    .is_prog  (is_prog),
    .is_sload (is_sload)
  );

  // Open-row tracking: programming is only honoured while idle.
  always_ff @(posedge clk) begin
    if (rst)         row_active <= 1'b0;
    else if (is_act) row_active <= 1'b1;
    else if (is_pre) row_active <= 1'b0;
  end

  assign prog_go = is_prog && !row_active;

  sgcfg_mode_reg #(
    .LAT_W   (LAT_W),
    .TEST_W  (TEST_W),
    .OUT_W   (2),
    .LAT_MAX (3),
    .LAT_RST (2)
  ) u_mode (
    .clk          (clk),
    .rst          (rst),
    .prog_go      (prog_go),
    .lat_code     (addr[LAT_LSB +: LAT_W]),
    .test_code    (addr[TEST_LSB +: TEST_W]),
    .mode_bit     (bank_sel),
    .reject       (prog_reject),
    .cas_lat      (cas_lat),
    .write_single (write_single)
  );

  // Index 0 = colour word, index 1 = mask word.
  assign sel_bits = {addr[MASK_B], addr[COLOR_B]};
  assign sel_both = &sel_bits;

  genvar gi;
  generate
    for (gi = 0; gi < N_WORDS; gi++) begin : g_word
      assign word_load[gi] = is_sload && sel_bits[gi] && !sel_both;
      sgcfg_word_reg #(.DATA_W(DATA_W)) u_word (
        .clk  (clk),
        .rst  (rst),
        .load (word_load[gi]),
        .din  (dq),
        .q    (word_q[gi])
      );
    end
  endgenerate

  assign color_q = word_q[0];
  assign mask_q  = word_q[1];

  always_ff @(posedge clk) begin
    if (rst) cmd_err <= 1'b0;
    else     cmd_err <= (prog_go && prog_reject) || (is_sload && sel_both);
  end
endmodule

// File: rtl/sgcfg_decoder_chk.sv
module sgcfg_decoder_chk #(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              dsf,
  input logic              bank_sel,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] dq,
  input logic [1:0]        cas_lat,
  input logic              write_single,
  input logic              row_active,
  input logic [DATA_W-1:0] color_q,
  input logic [DATA_W-1:0] mask_q,
  input logic              cmd_err
);
  logic quiet, sload, prog_idle, prog_bad;
  assign quiet     = cs_n || (ras_n && cas_n && we_n);
  assign sload     = !cs_n && !ras_n && !cas_n && !we_n && dsf;
  assign prog_idle = !cs_n && !ras_n && !cas_n && !we_n && !dsf && !row_active;
  assign prog_bad  = (addr[6:4] == 3'b000) || addr[6] || (addr[8:7] != 2'b00);

  // R7
  a_r7_quiet_stable: assert property (@(posedge clk) disable iff (rst)
    quiet |=> $stable(cas_lat) && $stable(write_single) && $stable(row_active)
              && $stable(color_q) && $stable(mask_q) && !cmd_err);

  // R5
  a_r5_color_load: assert property (@(posedge clk) disable iff (rst)
    (sload && addr[6] && !addr[5]) |=> (color_q == $past(dq)) && $stable(mask_q));

  a_r5_mask_load: assert property (@(posedge clk) disable iff (rst)
    (sload && addr[5] && !addr[6]) |=> (mask_q == $past(dq)) && $stable(color_q));

  // R6
  a_r6_both_illegal: assert property (@(posedge clk) disable iff (rst)
    (sload && addr[6] && addr[5]) |=> cmd_err && $stable(color_q) && $stable(mask_q));

  // R3
  a_r3_reject_keeps: assert property (@(posedge clk) disable iff (rst)
    (prog_idle && prog_bad) |=> cmd_err && $stable(cas_lat) && $stable(write_single));

  // R2
  a_r2_latency_nonzero: assert property (@(posedge clk) disable iff (rst)
    cas_lat != 2'd0);

  // R8
  a_r8_err_has_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(cmd_err) |-> $past((prog_idle && prog_bad) || (sload && addr[6] && addr[5])));
endmodule

bind sgcfg_decoder sgcfg_decoder_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sgcfg_decoder_test.sv
`timescale 1ns/1ps
module sgcfg_decoder_test;
  logic        clk = 1'b0;
  logic        rst;
  logic        cs_n, ras_n, cas_n, we_n, dsf, bank_sel;
  logic [9:0]  addr;
  logic [31:0] dq;
  logic [1:0]  cas_lat;
  logic        write_single, row_active, cmd_err;
  logic [31:0] color_q, mask_q;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [1:0]  m_lat;
  logic        m_ws;
  logic [31:0] m_color, m_mask;

  always #2.5 clk = ~clk;

  sgcfg_decoder uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dsf(dsf), .bank_sel(bank_sel), .addr(addr), .dq(dq), .cas_lat(cas_lat),
    .write_single(write_single), .row_active(row_active), .color_q(color_q),
    .mask_q(mask_q), .cmd_err(cmd_err)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_nop();
    cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; dsf = 1'b0;
  endtask

  // Drive one command for one edge, return to NOP at the next falling edge.
  task automatic issue(input logic c, input logic r, input logic ca, input logic w,
                       input logic d, input logic b, input logic [9:0] a,
                       input logic [31:0] data);
    @(negedge clk);
    cs_n = c; ras_n = r; cas_n = ca; we_n = w; dsf = d; bank_sel = b; addr = a; dq = data;
    @(negedge clk);
    set_nop();
  endtask

  task automatic check_state(input string req);
    check(req, 32'(cas_lat), 32'(m_lat));
    check(req, 32'(write_single), 32'(m_ws));
    check(req, color_q, m_color);
    check(req, mask_q, m_mask);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; set_nop(); bank_sel = 1'b0; addr = '0; dq = '0;
    repeat (3) @(negedge clk);
    check("R1", 32'(cas_lat), 32'd2);
    rst = 1'b0;
    @(negedge clk);
    m_lat = 2'd2; m_ws = 1'b0; m_color = '0; m_mask = '0;
    check_state("R1");
    check("R1", 32'(row_active), 32'd0);
    check("R1", 32'(cmd_err), 32'd0);

    // R2/R3 sweep of every mode-programming encoding while idle.
    for (int code = 0; code < 8; code++)
      for (int tst = 0; tst < 4; tst++)
        for (int hi = 0; hi < 2; hi++)
          for (int bs = 0; bs < 2; bs++) begin
            bit legal;
            legal = (code >= 1) && (code <= 3) && (tst == 0);
            issue(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, bs[0],
                  {hi[0], tst[1:0], code[2:0], 4'(code * 3 + bs)}, 32'hDEAD_0000 + 32'(code));
            if (legal) begin m_lat = code[1:0]; m_ws = bs[0]; end
            check(legal ? "R2" : "R3", 32'(cas_lat), 32'(m_lat));
            check(legal ? "R2" : "R3", 32'(write_single), 32'(m_ws));
            check("R3", 32'(cmd_err), legal ? 32'd0 : 32'd1);
            @(negedge clk);
            check("R8", 32'(cmd_err), 32'd0);
          end

    // Set a known mode: latency 1, burst writes.
    issue(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'b00_0001_0000, '0);
    m_lat = 2'd1; m_ws = 1'b0;
    check_state("R2");

    // R4: activate, then programming is ignored.
    issue(1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
    check("R4", 32'(row_active), 32'd1);
    issue(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'b00_0011_0000, '0);
    check_state("R4");
    check("R4", 32'(cmd_err), 32'd0);
    issue(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 10'b00_0000_0000, '0);
    check("R4", 32'(cmd_err), 32'd0);
    check_state("R4");

    // R5/R6 sweep of special loads, first with the row open, then idle.
    for (int i = 0; i < 16; i++) begin
      logic [31:0] w;
      logic [1:0]  sel;
      if (i == 8) begin
        issue(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, '0, '0);
        check("R4", 32'(row_active), 32'd0);
      end
      w   = 32'h9E37_79B9 * 32'(i + 1);
      sel = i[1:0];
      issue(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, i[2], {3'(i), sel[1], sel[0], 5'(i)}, w);
      if (sel == 2'b10) m_color = w;
      if (sel == 2'b01) m_mask = w;
      check(sel == 2'b11 ? "R6" : "R5", color_q, m_color);
      check(sel == 2'b11 ? "R6" : "R5", mask_q, m_mask);
      check(sel == 2'b11 ? "R6" : "R5", 32'(cmd_err), sel == 2'b11 ? 32'd1 : 32'd0);
      @(negedge clk);
      check("R8", 32'(cmd_err), 32'd0);
    end

    // R7: NOP and deselect with busy buses change nothing.
    issue(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 10'h3FF, 32'hFFFF_FFFF);
    check_state("R7");
    check("R7", 32'(cmd_err), 32'd0);
    issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 10'b00_0100_0000, 32'h1234_5678);
    check_state("R7");
    issue(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 10'b00_0011_0000, 32'h0);
    check_state("R7");
    issue(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, '0, '0);
    check("R7", 32'(row_active), 32'd0);
    check("R7", 32'(cmd_err), 32'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule